// File: doc/BRIEF.md
# Wait-State Read-Only Memory Bus Slave

This block is a read-only store of 8 KB, organised as 4096 halfwords of 16 bits, that answers reads on a 16-bit internal bus. A master presents a request with a byte address, an access size (byte, word or long), an address-space qualifier and a write flag. The slave splits the access into one, two or three back-to-back bus cycles, one halfword per cycle. It pulses a beat strobe at the end of each bus cycle and delivers the assembled big-endian result on its final beat. Every bus cycle lasts two clocks plus a programmable number of wait clocks. Slower memory can therefore be swapped for this one without changing the system's timing.

A small configuration port holds five settings, each with a reset value fixed by a parameter. They are the 8 KB-aligned base of the array, a two-bit mask of the address spaces served, the wait count, a boot-response enable and a write lock. With the boot enable set, the slave answers the eight bytes at address zero with a parameter-supplied reset vector, wherever its base is. The array contents are computed from a seed parameter, so no stored image is needed.

Top module: `rom_slave_top`

## Requirements
- R1: Halfword n of the array holds ((n × 40503) mod 65536) XOR SEED. An aligned word read at base + 2n returns that halfword in rsp_data[15:0], with the upper bits zero.
- R2: A byte read returns the byte in rsp_data[7:0], with the upper bits zero. An even address selects the high byte of its halfword and an odd address selects the low byte.
- R3: A word read at an odd address takes two beats. It returns {low byte of halfword n, high byte of halfword n+1} in rsp_data[15:0].
- R4: A long read takes two beats when aligned and three when misaligned. It returns the four bytes from the start address upward, in big-endian order. Byte offsets wrap modulo 8192 inside the array.
- R5: An accepted request, sampled while req_ready is high, produces its first beat 1+W clocks after the accepting edge. Later beats follow every 2+W clocks. rsp_done marks the last beat, and req_ready stays low from acceptance until the clock after rsp_done.
- R6: The wait count W is written through cfg_sel = 2 (field cfg_wdata[2:0]). It resets to RST_WAIT, and a new value applies to the next accepted request.
- R7: A request is served by the array only when req_addr[23:13] equals the base field. The base is written through cfg_sel = 0 (cfg_wdata[10:0]) and resets to RST_BASE. A request that does not decode is not accepted: no beat, and req_ready stays high.
- R8: The space mask is written through cfg_sel = 1 (cfg_wdata[1:0]) and resets to RST_SPACE. Bit 0 admits program fetches (req_space = 0) and bit 1 admits data reads (req_space = 1). A request of an excluded space is ignored as in R7.
- R9: The control field is written through cfg_sel = 3, with bit 0 as the boot enable and bit 1 as the lock. With the boot enable set, addresses 0 to 7 return the bytes of BOOT_VEC, most significant first, wrapping modulo 8. This takes priority over the array, even when the base is zero. With the boot enable clear, these addresses decode only through the base.
- R10: A write request that decodes gets a single beat, 1+W clocks after acceptance, with rsp_err and rsp_done high and rsp_data zero. The contents are unchanged afterwards.
- R11: While the lock is set, every configuration write is ignored, and the lock stays set until reset.
- R12: After reset, req_ready is high, no beat or done is signalled, and all configuration fields hold their parameter defaults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Slave idle and able to accept |
| req_addr | input | 24 | Byte address |
| req_size | input | 2 | 0 byte, 1 word, 2 or 3 long |
| req_space | input | 1 | 0 program fetch, 1 data read |
| req_write | input | 1 | Request is a write |
| rsp_beat | output | 1 | End of one bus cycle |
| rsp_done | output | 1 | Final beat of the access |
| rsp_err | output | 1 | Error response on the final beat |
| rsp_data | output | 32 | Assembled result, valid with rsp_done |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Configuration field select |
| cfg_wdata | input | 11 | Configuration write data |

## Verification
On every cycle the assertions check the following:
- the lock stays set once raised, and locked writes leave the configuration unchanged;
- consecutive beats are never adjacent, and with no wait states a beat follows acceptance at once;
- req_ready drops on acceptance and returns after done;
- misses, excluded spaces and writes to the array get the responses R7, R8 and R10 call for.

Only the bench's scenarios can show that the assembled data is right for every size and alignment, including wrap at the array end. The same applies to the exact beat positions for several wait counts, the boot-vector priority over a zero base, and the return of defaults after a second reset.

// File: rtl/rom_pkg.sv
package rom_pkg;

    localparam int ADDR_W     = 24;
    localparam int ROM_BYTE_AW = 13;
    localparam int HW_IDX_W   = ROM_BYTE_AW - 1;
    localparam int BASE_W     = ADDR_W - ROM_BYTE_AW;
    localparam int WAIT_W     = 3;
    localparam int CNT_W      = WAIT_W + 1;
    localparam int BOOT_BYTES = 8;
    localparam int BOOT_AW    = $clog2(BOOT_BYTES);

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_WORD = 2'd1,
        SZ_LONG = 2'd2,
        SZ_LONG_ALT = 2'd3
    } acc_size_e;

    typedef enum logic [1:0] {
        SEL_BASE  = 2'd0,
        SEL_SPACE = 2'd1,
        SEL_WAIT  = 2'd2,
        SEL_CTRL  = 2'd3
    } cfg_sel_e;

    typedef struct packed {
        logic [BASE_W-1:0] base;
        logic [1:0]        space_mask;
        logic [WAIT_W-1:0] wait_cyc;
        logic              boot_en;
        logic              lock;
    } cfg_t;

    typedef struct packed {
        logic                boot;
        logic                err;
        logic [HW_IDX_W-1:0] idx;
        logic                odd;
        acc_size_e           size;
        logic [1:0]          left;
        logic [WAIT_W-1:0]   wt;
    } acc_ctx_t;

    function automatic logic [15:0] rom_hw(input logic [HW_IDX_W-1:0] idx,
                                           input logic [15:0] seed);
        logic [31:0] prod;
        prod = 32'(idx) * 32'd40503;
        return prod[15:0] ^ seed;
    endfunction

    function automatic logic [1:0] beats_needed(input acc_size_e sz, input logic odd);
        case (sz)
            SZ_BYTE: return 2'd1;
            SZ_WORD: return odd ? 2'd2 : 2'd1;
            default: return odd ? 2'd3 : 2'd2;
        endcase
    endfunction

    function automatic logic [31:0] pack_result(input acc_size_e sz, input logic odd,
                                                input logic [23:0] hist,
                                                input logic [15:0] cur);
        case (sz)
            SZ_BYTE: return {24'h0, odd ? cur[7:0] : cur[15:8]};
            SZ_WORD: return odd ? {16'h0, hist[7:0], cur[15:8]} : {16'h0, cur};
            default: return odd ? {hist, cur[15:8]} : {hist[15:0], cur};
        endcase
    endfunction

endpackage

// File: rtl/rom_cfg_regs.sv
module rom_cfg_regs
    import rom_pkg::*;
#(
    parameter logic [BASE_W-1:0] RST_BASE  = 11'h004,
    parameter logic [1:0]        RST_SPACE = 2'b11,
    parameter logic [WAIT_W-1:0] RST_WAIT  = 3'd1,
    parameter logic              RST_BOOT  = 1'b1,
    parameter logic              RST_LOCK  = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  cfg_sel_e          cfg_sel,
    input  logic [BASE_W-1:0] cfg_wdata,
    output cfg_t              cfg
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg.base       <= RST_BASE;
            cfg.space_mask <= RST_SPACE;
            cfg.wait_cyc   <= RST_WAIT;
            cfg.boot_en    <= RST_BOOT;
            cfg.lock       <= RST_LOCK;
        end else if (cfg_we && !cfg.lock) begin
            case (cfg_sel)
                SEL_BASE:  cfg.base       <= cfg_wdata;
                SEL_SPACE: cfg.space_mask <= cfg_wdata[1:0];
                SEL_WAIT:  cfg.wait_cyc   <= cfg_wdata[WAIT_W-1:0];
                default: begin
                    cfg.boot_en <= cfg_wdata[0];
                    cfg.lock    <= cfg_wdata[1];
                end
            endcase
        end
    end

    // R11: lock holds until reset
    p_lock_sticky_r11: assert property (@(posedge clk) disable iff (rst)
        cfg.lock |=> cfg.lock);

    // R11: a locked write changes nothing
    p_locked_frozen_r11: assert property (@(posedge clk) disable iff (rst)
        (cfg.lock && cfg_we) |=> $stable(cfg));

endmodule

// File: rtl/rom_decode.sv
module rom_decode
    import rom_pkg::*;
(
    input  logic [ADDR_W-1:0]   addr,
    input  logic                space,
    input  cfg_t                cfg,
    output logic                hit_array,
    output logic                hit_boot,
    output logic [HW_IDX_W-1:0] idx,
    output logic                odd
);

    logic in_window;
    logic in_boot;
    logic space_ok;

    always_comb begin
        in_window = (addr[ADDR_W-1:ROM_BYTE_AW] == cfg.base);
        in_boot   = cfg.boot_en && (addr[ADDR_W-1:BOOT_AW] == '0);
        space_ok  = cfg.space_mask[space];
        hit_boot  = in_boot && space_ok;
        hit_array = in_window && space_ok && !in_boot;
        odd       = addr[0];
        if (in_boot)
            idx = {{(HW_IDX_W-BOOT_AW+1){1'b0}}, addr[BOOT_AW-1:1]};
        else
            idx = addr[ROM_BYTE_AW-1:1];
    end

endmodule

// File: rtl/rom_seq.sv
module rom_seq
    import rom_pkg::*;
#(
    parameter logic [15:0] SEED     = 16'h5A3C,
    parameter logic [63:0] BOOT_VEC = 64'h0000_2000_0000_8400
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    input  logic                req_write,
    input  acc_size_e           req_size,
    input  logic                hit_array,
    input  logic                hit_boot,
    input  logic [HW_IDX_W-1:0] idx,
    input  logic                odd,
    input  logic [WAIT_W-1:0]   wait_cyc,
    output logic                req_ready,
    output logic                rsp_beat,
    output logic                rsp_done,
    output logic                rsp_err,
    output logic [31:0]         rsp_data
);

    typedef enum logic {ST_IDLE, ST_RUN} seq_st_e;

    seq_st_e        state;
    logic [CNT_W-1:0] cnt;
    acc_ctx_t       ctx;
    logic [23:0]    hist;
    logic [15:0]    cur;
    logic           accept;

    function automatic logic [15:0] boot_hw(input logic [1:0] j);
        case (j)
            2'd0:    return BOOT_VEC[63:48];
            2'd1:    return BOOT_VEC[47:32];
            2'd2:    return BOOT_VEC[31:16];
            default: return BOOT_VEC[15:0];
        endcase
    endfunction

    always_comb begin
        accept    = req_valid && (state == ST_IDLE) && (hit_array || hit_boot);
        cur       = ctx.boot ? boot_hw(ctx.idx[1:0]) : rom_hw(ctx.idx, SEED);
        req_ready = (state == ST_IDLE);
        rsp_beat  = (state == ST_RUN) && (cnt == '0);
        rsp_done  = rsp_beat && (ctx.left == 2'd1);
        rsp_err   = rsp_done && ctx.err;
        rsp_data  = (rsp_done && !ctx.err) ? pack_result(ctx.size, ctx.odd, hist, cur) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cnt   <= '0;
            ctx   <= '0;
            hist  <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        state    <= ST_RUN;
                        cnt      <= {1'b0, wait_cyc};
                        ctx.boot <= hit_boot;
                        ctx.err  <= req_write;
                        ctx.idx  <= idx;
                        ctx.odd  <= odd;
                        ctx.size <= req_size;
                        ctx.left <= req_write ? 2'd1 : beats_needed(req_size, odd);
                        ctx.wt   <= wait_cyc;
                        hist     <= '0;
                    end
                end
                default: begin
                    if (rsp_beat) begin
                        if (rsp_done) begin
                            state <= ST_IDLE;
                        end else begin
                            cnt      <= {1'b0, ctx.wt} + CNT_W'(1);
                            ctx.left <= ctx.left - 2'd1;
                            ctx.idx  <= ctx.idx + HW_IDX_W'(1);
                            hist     <= {hist[7:0], cur};
                        end
                    end else begin
                        cnt <= cnt - CNT_W'(1);
                    end
                end
            endcase
        end
    end

    // R5: no wait states means a beat right after acceptance
    p_first_beat_r5: assert property (@(posedge clk) disable iff (rst)
        (accept && wait_cyc == '0) |=> rsp_beat);

    // R5: beats of one access never land on adjacent clocks
    p_beat_spacing_r5: assert property (@(posedge clk) disable iff (rst)
        (rsp_beat && !rsp_done) |=> !rsp_beat);

    // R5: acceptance makes the slave busy
    p_accept_busy_r5: assert property (@(posedge clk) disable iff (rst)
        accept |=> !req_ready);

    // R5: done frees the slave
    p_done_frees_r5: assert property (@(posedge clk) disable iff (rst)
        rsp_done |=> req_ready);

endmodule

// File: rtl/rom_slave_top.sv
module rom_slave_top
    import rom_pkg::*;
#(
    parameter logic [15:0]       SEED      = 16'h5A3C,
    parameter logic [63:0]       BOOT_VEC  = 64'h0000_2000_0000_8400,
    parameter logic [BASE_W-1:0] RST_BASE  = 11'h004,
    parameter logic [1:0]        RST_SPACE = 2'b11,
    parameter logic [WAIT_W-1:0] RST_WAIT  = 3'd1,
    parameter logic              RST_BOOT  = 1'b1,
    parameter logic              RST_LOCK  = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic              req_space,
    input  logic              req_write,
    output logic              rsp_beat,
    output logic              rsp_done,
    output logic              rsp_err,
    output logic [31:0]       rsp_data,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [BASE_W-1:0] cfg_wdata
);

    cfg_t                cfg;
    logic                hit_array;
    logic                hit_boot;
    logic [HW_IDX_W-1:0] idx;
    logic                odd;

    rom_cfg_regs #(
        .RST_BASE (RST_BASE),
        .RST_SPACE(RST_SPACE),
        .RST_WAIT (RST_WAIT),
        .RST_BOOT (RST_BOOT),
        .RST_LOCK (RST_LOCK)
    ) u_cfg (
        .clk      (clk),
        .rst      (rst),
        .cfg_we   (cfg_we),
        .cfg_sel  (cfg_sel_e'(cfg_sel)),
        .cfg_wdata(cfg_wdata),
        .cfg      (cfg)
    );

    rom_decode u_dec (
        .addr     (req_addr),
        .space    (req_space),
        .cfg      (cfg),
        .hit_array(hit_array),
        .hit_boot (hit_boot),
        .idx      (idx),
        .odd      (odd)
    );

    rom_seq #(
        .SEED    (SEED),
        .BOOT_VEC(BOOT_VEC)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .req_valid(req_valid),
        .req_write(req_write),
        .req_size (acc_size_e'(req_size)),
        .hit_array(hit_array),
        .hit_boot (hit_boot),
        .idx      (idx),
        .odd      (odd),
        .wait_cyc (cfg.wait_cyc),
        .req_ready(req_ready),
        .rsp_beat (rsp_beat),
        .rsp_done (rsp_done),
        .rsp_err  (rsp_err),
        .rsp_data (rsp_data)
    );

    // R7: a request outside the window and boot area leaves the slave idle
    p_miss_ignored_r7: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && !hit_array && !hit_boot) |=> req_ready);

    // R8: an excluded address space is never accepted
    p_space_block_r8: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && !cfg.space_mask[req_space]) |=> req_ready);

    // R10: a decoded write with no waits gets an error on the next clock
    p_write_error_r10: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && req_write && (hit_array || hit_boot)
         && cfg.wait_cyc == '0) |=> (rsp_err && rsp_done));

endmodule

// File: tb/rom_slave_top_tb_top.sv
module rom_slave_top_tb_top;

    localparam int          CLK_PERIOD = 10;
    localparam logic [15:0] SEED       = 16'h5A3C;
    localparam logic [63:0] BOOT_VEC   = 64'h0000_2000_0000_8400;
    localparam int          WATCHDOG   = 50000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [23:0] req_addr = '0;
    logic [1:0]  req_size = '0;
    logic        req_space = 1'b0;
    logic        req_write = 1'b0;
    logic        rsp_beat;
    logic        rsp_done;
    logic        rsp_err;
    logic [31:0] rsp_data;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic [10:0] cfg_wdata = '0;

    int n_run  = 0;
    int n_fail = 0;
    int wt     = 1;

    always #(CLK_PERIOD/2) clk = ~clk;

    rom_slave_top dut_i (
        .clk      (clk),
        .rst      (rst),
        .req_valid(req_valid),
        .req_ready(req_ready),
        .req_addr (req_addr),
        .req_size (req_size),
        .req_space(req_space),
        .req_write(req_write),
        .rsp_beat (rsp_beat),
        .rsp_done (rsp_done),
        .rsp_err  (rsp_err),
        .rsp_data (rsp_data),
        .cfg_we   (cfg_we),
        .cfg_sel  (cfg_sel),
        .cfg_wdata(cfg_wdata)
    );

    function automatic logic [7:0] arr_byte(input int unsigned b);
        int unsigned n;
        logic [31:0] p;
        logic [15:0] h;
        n = (b % 8192) / 2;
        p = n * 40503;
        h = p[15:0] ^ SEED;
        return (b % 2 == 0) ? h[15:8] : h[7:0];
    endfunction

    function automatic logic [7:0] boot_byte(input int unsigned b);
        int unsigned k;
        k = b % 8;
        return BOOT_VEC[63 - 8*k -: 8];
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [1:0] sel, input logic [10:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // mode: 0 miss, 1 array, 2 boot area, 3 error response
    task automatic access(input logic [23:0] a, input int sz, input logic sp,
                          input logic wr, input int mode, input string req);
        int unsigned off;
        int nb;
        int nbeats;
        int last_s;
        logic [31:0] expd;
        logic [31:0] got;
        logic goterr;
        bit tfail;
        nb   = (sz == 0) ? 1 : ((sz == 1) ? 2 : 4);
        off  = (mode == 2) ? int'(a[2:0]) : int'(a[12:0]);
        expd = '0;
        for (int i = 0; i < nb; i++)
            expd = (expd << 8) | 32'((mode == 2) ? boot_byte(off + i) : arr_byte(off + i));
        nbeats = (mode == 3) ? 1 : int'((off + nb - 1) / 2 - off / 2 + 1);
        last_s = nbeats * (2 + wt) - 1;
        got = '0; goterr = 1'b0; tfail = 1'b0;
        @(negedge clk);
        req_addr = a; req_size = 2'(sz); req_space = sp; req_write = wr; req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        if (mode == 0) begin
            for (int s = 1; s <= 12; s++) begin
                if (rsp_beat || rsp_done || !req_ready) tfail = 1'b1;
                @(negedge clk);
            end
            chk(!tfail, req, "request ignored", {31'b0, tfail}, 32'h0);
        end else begin
            for (int s = 1; s <= last_s + 1; s++) begin
                bit eb;
                bit el;
                eb = (s >= 1 + wt) && ((s - 1 - wt) % (2 + wt) == 0)
                     && ((s - 1 - wt) / (2 + wt) < nbeats);
                el = eb && (s == last_s);
                if (rsp_beat !== eb || rsp_done !== el || req_ready !== (s > last_s))
                    tfail = 1'b1;
                if (el) begin got = rsp_data; goterr = rsp_err; end
                if (s <= last_s) @(negedge clk);
            end
            chk(!tfail, req, "beat timing", 32'(tfail), 32'h0);
            if (mode == 3)
                chk(goterr && got == 0, req, "error response", {got[30:0], goterr}, 32'h1);
            else
                chk(!goterr && got == expd, req, "data", got, expd);
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected below %0d cycles", WATCHDOG, WATCHDOG);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R12 idle after reset
        chk(req_ready && !rsp_beat && !rsp_done, "R12", "reset outputs",
            {29'b0, req_ready, rsp_beat, rsp_done}, 32'h4);

        // R1 aligned words at the reset base with the reset wait count (R12 defaults)
        access(24'h008010, 1, 1'b0, 1'b0, 1, "R1");
        access(24'h009FFE, 1, 1'b1, 1'b0, 1, "R1");
        // R2 bytes
        access(24'h008020, 0, 1'b1, 1'b0, 1, "R2");
        access(24'h008021, 0, 1'b0, 1'b0, 1, "R2");
        // R3 misaligned word
        access(24'h008033, 1, 1'b1, 1'b0, 1, "R3");
        // R4 longs, including wrap at the end of the array
        access(24'h008040, 2, 1'b0, 1'b0, 1, "R4");
        access(24'h008045, 3, 1'b1, 1'b0, 1, "R4");
        access(24'h009FFE, 2, 1'b0, 1'b0, 1, "R4");
        access(24'h009FFF, 2, 1'b1, 1'b0, 1, "R4");
        // R9 boot vector with reset enable
        access(24'h000000, 2, 1'b0, 1'b0, 2, "R9");
        access(24'h000004, 2, 1'b0, 1'b0, 2, "R9");
        access(24'h000007, 1, 1'b1, 1'b0, 2, "R9");

        // R6 wait count changes
        cfg_write(2'd2, 11'd0); wt = 0;
        access(24'h008010, 1, 1'b0, 1'b0, 1, "R6");
        access(24'h008045, 2, 1'b0, 1'b0, 1, "R6");
        cfg_write(2'd2, 11'd4); wt = 4;
        access(24'h008045, 2, 1'b1, 1'b0, 1, "R6");
        cfg_write(2'd2, 11'd2); wt = 2;

        // R7 relocation
        cfg_write(2'd0, 11'h0C0);
        access(24'h180010, 1, 1'b0, 1'b0, 1, "R7");
        access(24'h008010, 1, 1'b0, 1'b0, 0, "R7");

        // R8 space mask
        cfg_write(2'd1, 11'b01);
        access(24'h180010, 1, 1'b1, 1'b0, 0, "R8");
        access(24'h180012, 1, 1'b0, 1'b0, 1, "R8");
        access(24'h000000, 1, 1'b1, 1'b0, 0, "R8");
        cfg_write(2'd1, 11'b10);
        access(24'h180012, 1, 1'b0, 1'b0, 0, "R8");
        access(24'h180012, 1, 1'b1, 1'b0, 1, "R8");
        cfg_write(2'd1, 11'b11);

        // R10 write to the array
        access(24'h180010, 1, 1'b1, 1'b1, 3, "R10");
        access(24'h180010, 1, 1'b1, 1'b0, 1, "R10");
        access(24'h300010, 1, 1'b1, 1'b1, 0, "R10");

        // R9 boot enable off, then on with a zero base
        cfg_write(2'd3, 11'b00);
        access(24'h000000, 1, 1'b0, 1'b0, 0, "R9");
        cfg_write(2'd0, 11'h000);
        access(24'h000000, 2, 1'b0, 1'b0, 1, "R9");
        cfg_write(2'd3, 11'b01);
        access(24'h000002, 2, 1'b0, 1'b0, 2, "R9");

        // R11 lock
        cfg_write(2'd3, 11'b11);
        cfg_write(2'd2, 11'd0);
        access(24'h000010, 1, 1'b0, 1'b0, 1, "R11");
        cfg_write(2'd0, 11'h0C0);
        access(24'h180010, 1, 1'b0, 1'b0, 0, "R11");
        cfg_write(2'd3, 11'b00);
        access(24'h000000, 1, 1'b0, 1'b0, 2, "R11");

        // R12 second reset restores defaults
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        wt = 1;
        chk(req_ready && !rsp_beat, "R12", "reset outputs again",
            {30'b0, req_ready, rsp_beat}, 32'h2);
        access(24'h008010, 1, 1'b0, 1'b0, 1, "R12");
        access(24'h000000, 2, 1'b1, 1'b0, 2, "R12");
        cfg_write(2'd2, 11'd0); wt = 0;
        access(24'h008012, 1, 1'b0, 1'b0, 1, "R12");

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule